// File: doc/BRIEF.md
# Wait-for-interrupt power mode controller

This block moves a small CPU core into a low-power wait state and back out again. When the core decodes a wait-for-interrupt instruction it raises a one-cycle strobe. The block then turns off the CPU clock enable and keeps the oscillator and peripheral clock enables on. It also clears the global interrupt mask bit, so that any interrupt source can wake the core.

The block leaves wait on an interrupt request or on reset. On an interrupt it turns the CPU clock back on and gives a one-cycle service pulse. During that pulse the mask bit still holds its value from wait, so the core can push it to the stack. From the next cycle on the mask bit is set. A later pop of the condition codes writes the popped bit back into the mask.

On reset the block runs a stabilisation delay of 256 or 4096 clock cycles. During the delay the CPU and peripheral clock enables are off and the oscillator enable stays on. After the delay it gives a one-cycle fetch-reset-vector pulse. After either pulse the block waits for the core's acknowledge and then returns to run.

The states are:
- RST_DELAY: reset stabilisation.
- RST_VECTOR: fetch pulse.
- RST_ACK: waiting for acknowledge after the fetch pulse.
- RUN
- WAIT
- IRQ_VECTOR: service pulse.
- IRQ_ACK: waiting for acknowledge after the service pulse.

The transitions are:
- reset release → RST_DELAY
- RST_DELAY → RST_VECTOR when the delay expires
- RST_VECTOR → RST_ACK
- RST_ACK → RUN on acknowledge
- RUN → WAIT on the instruction strobe
- WAIT → IRQ_VECTOR on an interrupt request
- IRQ_VECTOR → IRQ_ACK
- IRQ_ACK → RUN on acknowledge
- any state → RST_DELAY while reset is asserted

Top module: `wfi_power_ctl`

## Requirements
- R1: While reset is low, and in RST_DELAY, the outputs are as follows: cpu_clk_en=0, periph_clk_en=0, osc_en=1, imask=1, and both wake pulses are 0.
- R2: The delay length is set by long_delay_sel, which must stay stable during the delay (0 selects 256 cycles, 1 selects 4096 cycles). fetch_rst_pulse first goes high exactly that many rising clock edges after rst_n is released.
- R3: fetch_rst_pulse lasts one cycle. From the pulse on, cpu_clk_en=1. The block holds until wake_ack is seen and then enters RUN. The two wake pulses are never high together.
- R4: A wfi_strobe in RUN enters WAIT at the next edge. From then on cpu_clk_en=0, osc_en=1, periph_clk_en=1 and imask=0.
- R5: WAIT is left only on irq_req (or reset). wfi_strobe and wake_ack have no effect in WAIT.
- R6: irq_req in WAIT gives, on the next cycle, svc_irq_pulse=1 for one cycle with cpu_clk_en=1 and imask still 0. From the following cycle on, imask=1.
- R7: After svc_irq_pulse, the block holds with cpu_clk_en=1 until wake_ack and then enters RUN, where a new wfi_strobe is accepted.
- R8: cc_pop_vld loads cc_pop_ibit into imask at the next edge. Two events take priority over a pop in the same cycle: wait entry (imask=0) and the service pulse cycle (imask=1).
- R9: irq_req has no effect in RUN, RST_DELAY or the ack states. No svc_irq_pulse follows it.
- R10: Reset wins over everything. A reset in WAIT, even with irq_req high in the same cycles, leads to the reset path and fetch_rst_pulse, never to svc_irq_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| long_delay_sel | input | 1 | 0: 256-cycle reset delay, 1: 4096-cycle reset delay |
| wfi_strobe | input | 1 | Decoded wait-for-interrupt instruction |
| irq_req | input | 1 | Any pending interrupt request |
| wake_ack | input | 1 | Core accepts the wake pulse |
| cc_pop_vld | input | 1 | Condition codes popped from the stack |
| cc_pop_ibit | input | 1 | Mask bit value being popped |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| imask | output | 1 | Interrupt mask bit of the condition codes |
| svc_irq_pulse | output | 1 | One-cycle command to service an interrupt |
| fetch_rst_pulse | output | 1 | One-cycle command to fetch the reset vector |

## Verification
Inputs change 1 ns after a rising edge, and outputs are sampled at the falling edge. The checks are timed as follows:
- The wait entry results (clocks and mask) are due one edge after the strobe.
- The service pulse is due one edge after irq_req, and the mask bit rises one edge after that.
- A popped mask bit is due one edge after cc_pop_vld.
- The fetch pulse is due exactly 256 or 4096 edges after reset release.

Each expected wake pulse is queued with the cycle number at which it must appear. A monitor compares every observed pulse, at each falling edge, against the head of that queue. Any pulse that was not queued, such as one after an irq_req during reset or in RUN, counts as a miscompare.

// File: rtl/wfi_pkg.sv
package wfi_pkg;

    typedef enum logic [2:0] {
        ST_RST_DELAY  = 3'd0,
        ST_RST_VECTOR = 3'd1,
        ST_RST_ACK    = 3'd2,
        ST_RUN        = 3'd3,
        ST_WAIT       = 3'd4,
        ST_IRQ_VECTOR = 3'd5,
        ST_IRQ_ACK    = 3'd6
    } wfi_state_e;

endpackage

// File: rtl/wfi_stall_timer.sv
// Counts the post-reset stabilisation window; expired is high in its last cycle.
module wfi_stall_timer #(
    parameter int SHORT_TICKS = 256,
    parameter int LONG_TICKS  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_sel,
    input  logic run_en,
    output logic expired
);
    localparam int CNT_W = $clog2(LONG_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit   = long_sel ? CNT_W'(LONG_TICKS - 1) : CNT_W'(SHORT_TICKS - 1);
    assign expired = run_en && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run_en && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wfi_imask_reg.sv
// Interrupt mask bit: set by reset, cleared on wait entry, set on service,
// otherwise loaded by a condition-code pop.
module wfi_imask_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_wait,
    input  logic set_service,
    input  logic pop_vld,
    input  logic pop_bit,
    output logic imask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imask <= 1'b1;
        end else if (clr_wait) begin
            imask <= 1'b0;
        end else if (set_service) begin
            imask <= 1'b1;
        end else if (pop_vld) begin
            imask <= pop_bit;
        end
    end
endmodule

// File: rtl/wfi_seq_fsm.sv
module wfi_seq_fsm
    import wfi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_strobe,
    input  logic       irq_req,
    input  logic       wake_ack,
    input  logic       delay_done,
    output wfi_state_e state,
    output logic       delay_run,
    output logic       enter_wait,
    output logic       enter_service,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       periph_clk_en,
    output logic       svc_irq_pulse,
    output logic       fetch_rst_pulse
);
    wfi_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RST_DELAY;
        end else begin
            state <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_RST_DELAY:  if (delay_done) state_d = ST_RST_VECTOR;
            ST_RST_VECTOR: state_d = ST_RST_ACK;
            ST_RST_ACK:    if (wake_ack) state_d = ST_RUN;
            ST_RUN:        if (wfi_strobe) state_d = ST_WAIT;
            ST_WAIT:       if (irq_req) state_d = ST_IRQ_VECTOR;
            ST_IRQ_VECTOR: state_d = ST_IRQ_ACK;
            ST_IRQ_ACK:    if (wake_ack) state_d = ST_RUN;
            default:       state_d = ST_RST_DELAY;
        endcase
    end

    // outputs
    always_comb begin
        delay_run       = 1'b0;
        cpu_clk_en      = 1'b1;
        osc_en          = 1'b1;
        periph_clk_en   = 1'b1;
        svc_irq_pulse   = 1'b0;
        fetch_rst_pulse = 1'b0;
        enter_wait      = 1'b0;
        enter_service   = 1'b0;
        unique case (state)
            ST_RST_DELAY: begin
                delay_run     = 1'b1;
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
            end
            ST_RST_VECTOR: fetch_rst_pulse = 1'b1;
            ST_RST_ACK:    ;
            ST_RUN:        enter_wait = wfi_strobe;
            ST_WAIT:       cpu_clk_en = 1'b0;
            ST_IRQ_VECTOR: begin
                svc_irq_pulse = 1'b1;
                enter_service = 1'b1;
            end
            ST_IRQ_ACK:    ;
            default: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wfi_power_ctl.sv
module wfi_power_ctl
    import wfi_pkg::*;
#(
    parameter int SHORT_TICKS = 256,
    parameter int LONG_TICKS  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_delay_sel,
    input  logic wfi_strobe,
    input  logic irq_req,
    input  logic wake_ack,
    input  logic cc_pop_vld,
    input  logic cc_pop_ibit,
    output logic cpu_clk_en,
    output logic osc_en,
    output logic periph_clk_en,
    output logic imask,
    output logic svc_irq_pulse,
    output logic fetch_rst_pulse
);
    wfi_state_e state_q;
    logic       delay_run;
    logic       delay_done;
    logic       enter_wait;
    logic       enter_service;

    wfi_stall_timer #(
        .SHORT_TICKS(SHORT_TICKS),
        .LONG_TICKS (LONG_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .long_sel(long_delay_sel),
        .run_en  (delay_run),
        .expired (delay_done)
    );

    wfi_seq_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wfi_strobe     (wfi_strobe),
        .irq_req        (irq_req),
        .wake_ack       (wake_ack),
        .delay_done     (delay_done),
        .state          (state_q),
        .delay_run      (delay_run),
        .enter_wait     (enter_wait),
        .enter_service  (enter_service),
        .cpu_clk_en     (cpu_clk_en),
        .osc_en         (osc_en),
        .periph_clk_en  (periph_clk_en),
        .svc_irq_pulse  (svc_irq_pulse),
        .fetch_rst_pulse(fetch_rst_pulse)
    );

    wfi_imask_reg u_imask (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_wait   (enter_wait),
        .set_service(enter_service),
        .pop_vld    (cc_pop_vld),
        .pop_bit    (cc_pop_ibit),
        .imask      (imask)
    );
endmodule

// File: rtl/wfi_power_ctl_chk.sv
module wfi_power_ctl_chk
    import wfi_pkg::*;
#(
    parameter int SHORT_TICKS = 256,
    parameter int LONG_TICKS  = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       long_delay_sel,
    input logic       wfi_strobe,
    input logic       irq_req,
    input logic       wake_ack,
    input logic       cc_pop_vld,
    input logic       cc_pop_ibit,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic       periph_clk_en,
    input logic       imask,
    input logic       svc_irq_pulse,
    input logic       fetch_rst_pulse,
    input wfi_state_e st
);
    logic [15:0] dly_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_cnt <= '0;
        else if (st == ST_RST_DELAY) dly_cnt <= dly_cnt + 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RST_DELAY) |-> (!cpu_clk_en && !periph_clk_en && osc_en && imask
                                  && !svc_irq_pulse && !fetch_rst_pulse));

    assert_delay_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rst_pulse |-> (dly_cnt == (long_delay_sel ? 16'(LONG_TICKS) : 16'(SHORT_TICKS))));

    assert_fetch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rst_pulse |=> (!fetch_rst_pulse && cpu_clk_en));

    assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({svc_irq_pulse, fetch_rst_pulse}));

    assert_wait_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wfi_strobe) |=> (!cpu_clk_en && periph_clk_en && osc_en && !imask));

    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !irq_req) |=> (st == ST_WAIT && !cpu_clk_en));

    assert_irq_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && irq_req) |=> (svc_irq_pulse && cpu_clk_en && !imask));

    assert_service_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq_pulse |=> (imask && !svc_irq_pulse));

    assert_ack_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IRQ_ACK && wake_ack) |=> (st == ST_RUN && cpu_clk_en));

    assert_pop_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_pop_vld && !wfi_strobe && st != ST_IRQ_VECTOR) |=> (imask == $past(cc_pop_ibit)));

    assert_no_stray_svc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_WAIT) |=> !svc_irq_pulse);
endmodule

bind wfi_power_ctl wfi_power_ctl_chk #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .long_delay_sel (long_delay_sel),
    .wfi_strobe     (wfi_strobe),
    .irq_req        (irq_req),
    .wake_ack       (wake_ack),
    .cc_pop_vld     (cc_pop_vld),
    .cc_pop_ibit    (cc_pop_ibit),
    .cpu_clk_en     (cpu_clk_en),
    .osc_en         (osc_en),
    .periph_clk_en  (periph_clk_en),
    .imask          (imask),
    .svc_irq_pulse  (svc_irq_pulse),
    .fetch_rst_pulse(fetch_rst_pulse),
    .st             (state_q)
);

// File: tb/wfi_power_ctl_test.sv
module wfi_power_ctl_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, long_delay_sel = 1'b0, wfi_strobe = 1'b0, irq_req = 1'b0;
    logic wake_ack = 1'b0, cc_pop_vld = 1'b0, cc_pop_ibit = 1'b0;
    logic cpu_clk_en, osc_en, periph_clk_en, imask, svc_irq_pulse, fetch_rst_pulse;

    wfi_power_ctl uut (
        .clk(clk), .rst_n(rst_n), .long_delay_sel(long_delay_sel),
        .wfi_strobe(wfi_strobe), .irq_req(irq_req), .wake_ack(wake_ack),
        .cc_pop_vld(cc_pop_vld), .cc_pop_ibit(cc_pop_ibit),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .periph_clk_en(periph_clk_en),
        .imask(imask), .svc_irq_pulse(svc_irq_pulse), .fetch_rst_pulse(fetch_rst_pulse)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int vectors = 0;
    int miscompares = 0;

    typedef struct {
        logic        is_fetch;
        int unsigned when;
        string       req;
    } ev_t;
    ev_t exp_q[$];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // monitor: every wake pulse must match the head of the expected queue
    always @(negedge clk) begin : mon
        ev_t e;
        if (rst_n === 1'b1 && (svc_irq_pulse === 1'b1 || fetch_rst_pulse === 1'b1)) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R9/R10 unexpected pulse: actual svc=%0b fetch=%0b at %0d expected none",
                         svc_irq_pulse, fetch_rst_pulse, cyc);
            end else begin
                e = exp_q.pop_front();
                if (e.is_fetch !== fetch_rst_pulse || e.is_fetch === svc_irq_pulse || e.when != cyc) begin
                    miscompares++;
                    $display("FAIL %s pulse: actual fetch=%0b at %0d expected fetch=%0b at %0d",
                             e.req, fetch_rst_pulse, cyc, e.is_fetch, e.when);
                end
            end
        end
    end

    task automatic do_ack();
        @(posedge clk); #1 wake_ack = 1'b1;
        @(posedge clk); #1 wake_ack = 1'b0;
    endtask

    task automatic pulse_wfi();
        @(posedge clk); #1 wfi_strobe = 1'b1;
        @(posedge clk); #1 wfi_strobe = 1'b0;
    endtask

    // reset with irq_req held high through the start of the delay (R9, R10)
    task automatic do_reset(logic sel);
        int unsigned n;
        n = sel ? 4096 : 256;
        #1 rst_n = 1'b0; irq_req = 1'b1; long_delay_sel = sel;
        wfi_strobe = 1'b0; wake_ack = 1'b0; cc_pop_vld = 1'b0;
        @(negedge clk);
        chk("R1", "cpu_clk_en in reset", 32'(cpu_clk_en), 0);
        chk("R10", "svc pulse with reset+irq", 32'(svc_irq_pulse), 0);
        repeat (3) @(posedge clk);
        #1;
        exp_q.push_back('{1'b1, cyc + n, "R2"});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cpu_clk_en", 32'(cpu_clk_en), 0);
        chk("R1", "periph_clk_en", 32'(periph_clk_en), 0);
        chk("R1", "osc_en", 32'(osc_en), 1);
        chk("R1", "imask", 32'(imask), 1);
        repeat (10) @(posedge clk);
        #1 irq_req = 1'b0;
        repeat (n - 11) @(posedge clk);
        @(negedge clk);
        chk("R2", "fetch one cycle early", 32'(fetch_rst_pulse), 0);
        chk("R9", "svc during delay", 32'(svc_irq_pulse), 0);
        @(negedge clk);
        chk("R2", "fetch_rst_pulse at delay end", 32'(fetch_rst_pulse), 1);
        chk("R3", "cpu_clk_en at fetch", 32'(cpu_clk_en), 1);
        @(negedge clk);
        chk("R3", "fetch pulse width", 32'(fetch_rst_pulse), 0);
        chk("R3", "cpu_clk_en awaiting ack", 32'(cpu_clk_en), 1);
        do_ack();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        // short delay reset path
        do_reset(1'b0);

        // R9: irq_req in RUN is ignored
        @(posedge clk); #1 irq_req = 1'b1;
        repeat (3) @(posedge clk);
        #1 irq_req = 1'b0;
        @(negedge clk);
        chk("R9", "cpu_clk_en in run", 32'(cpu_clk_en), 1);
        chk("R9", "svc in run", 32'(svc_irq_pulse), 0);

        // R8: pop loads mask
        @(posedge clk); #1 cc_pop_vld = 1'b1; cc_pop_ibit = 1'b0;
        @(posedge clk); #1 cc_pop_vld = 1'b0;
        @(negedge clk);
        chk("R8", "imask after pop 0", 32'(imask), 0);
        @(posedge clk); #1 cc_pop_vld = 1'b1; cc_pop_ibit = 1'b1;
        @(posedge clk); #1 cc_pop_vld = 1'b0;
        @(negedge clk);
        chk("R8", "imask after pop 1", 32'(imask), 1);

        // R4: enter wait
        pulse_wfi();
        @(negedge clk);
        chk("R4", "cpu_clk_en in wait", 32'(cpu_clk_en), 0);
        chk("R4", "osc_en in wait", 32'(osc_en), 1);
        chk("R4", "periph_clk_en in wait", 32'(periph_clk_en), 1);
        chk("R4", "imask in wait", 32'(imask), 0);

        // R5: strobe and ack ignored in wait
        repeat (4) @(posedge clk);
        pulse_wfi();
        do_ack();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5", "cpu_clk_en still off", 32'(cpu_clk_en), 0);
        chk("R5", "imask still clear", 32'(imask), 0);

        // R6: interrupt wake
        @(posedge clk); #1 irq_req = 1'b1;
        exp_q.push_back('{1'b0, cyc + 1, "R6"});
        @(posedge clk); #1 irq_req = 1'b0;
        @(negedge clk);
        chk("R6", "svc_irq_pulse", 32'(svc_irq_pulse), 1);
        chk("R6", "cpu_clk_en on wake", 32'(cpu_clk_en), 1);
        chk("R6", "imask during push", 32'(imask), 0);
        @(negedge clk);
        chk("R6", "svc pulse width", 32'(svc_irq_pulse), 0);
        chk("R6", "imask in service", 32'(imask), 1);

        // R7: holds until ack, then run accepts wfi again
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7", "cpu_clk_en awaiting ack", 32'(cpu_clk_en), 1);
        do_ack();
        @(negedge clk);
        chk("R7", "cpu_clk_en in run", 32'(cpu_clk_en), 1);
        @(posedge clk); #1 cc_pop_vld = 1'b1; cc_pop_ibit = 1'b0;
        @(posedge clk); #1 cc_pop_vld = 1'b0;
        @(negedge clk);
        chk("R8", "imask restored by pop", 32'(imask), 0);

        // R8: pop of 1 together with wfi: wait entry wins
        @(posedge clk); #1 cc_pop_vld = 1'b1; cc_pop_ibit = 1'b1; wfi_strobe = 1'b1;
        @(posedge clk); #1 cc_pop_vld = 1'b0; wfi_strobe = 1'b0;
        @(negedge clk);
        chk("R8", "imask wait beats pop", 32'(imask), 0);
        chk("R7", "wfi accepted after ack", 32'(cpu_clk_en), 0);

        // R10: reset from wait with irq high -> reset path, long delay
        repeat (2) @(posedge clk);
        do_reset(1'b1);

        repeat (4) @(posedge clk);
        chk("R10", "leftover expected pulses", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule